// File: doc/BRIEF.md
# Conditional Scratch Swap Unit

This block holds the per-privilege scratch registers of a hart and executes the special register-swap accesses that trap entry and exit code uses to exchange the stack pointer with a saved scratch value. Each scratch register sits behind three access targets. The first is a plain access with ordinary CSR read-modify-write behaviour. The second is a privilege-conditioned swap. The third is a level-conditioned swap.

For the swap targets, the value returned to the destination register differs from the value used for the write. On a swap the destination receives the old scratch value and the scratch register takes the source operand. Without a swap the destination receives the source operand unchanged and the scratch register keeps its value. Whether a swap happens depends only on the hart state presented on the inputs. For the privilege swap this is the saved previous privilege against the current privilege. For the level swap it is whether the saved previous interrupt level and the active interrupt level are zero.

An access is issued for one cycle with `op_valid`. Every result appears on the registered outputs one clock later, and any scratch update takes effect at that same edge. A reserved access raises a one-cycle illegal flag and changes nothing. Trap generation beyond that flag is handled elsewhere.

Top module: `cswp_unit`

## Requirements
- R1: After reset both scratch registers read as zero, and `rd_we`, `rd_val`, `scr_we`, `scr_wdata` and `illegal` are all zero.
- R2: A legal privilege-swap access (`op_tgt`=1) with `prev_priv` different from `cur_priv` returns the old scratch value on `rd_val`, writes the source operand into the scratch register, and shows `scr_we`=1 with `scr_wdata` equal to the source.
- R3: A legal privilege-swap access with `prev_priv` equal to `cur_priv` returns `src_val` on `rd_val` and leaves the scratch register unchanged (`scr_we`=0).
- R4: A legal level-swap access (`op_tgt`=2) swaps exactly when (`prev_lvl`==0) XOR (`act_lvl`==0). It uses the same result rules as R2 when swapping and R3 when not.
- R5: A swap access is legal only with form code 1 (register write-swap) and with neither `rd_idx` nor `rs1_idx` equal to 0. Any other form, either index 0, form codes 0 and 4 on any target, and target code 3 are reserved and raise `illegal`.
- R6: An access to the registers of a mode more privileged than `cur_priv` raises `illegal` (privilege codes U=0, S=1, M=3).
- R7: Only modes above the lowest have scratch registers. Mode code 0 (U) and code 2 always raise `illegal`, and mode S (1) also raises it when the supervisor slot is not built (`HAS_S`=0).
- R8: A legal plain access (`op_tgt`=0) returns the old scratch value when `rd_idx`≠0. Form codes 1/2/3 write/set/clear with `src_val` as the operand, and 5/6/7 do the same with `rs1_idx` zero-extended. Set and clear forms with `rs1_idx`=0 do not write.
- R9: Results are due on the registered outputs one cycle after `op_valid`. Cycles without `op_valid` leave all enables and `illegal` low and `rd_val`/`scr_wdata` zero, and `rd_val` is zero whenever `rd_we` is low.
- R10: Every legal swap access asserts `rd_we`, whether or not the swap happens.
- R11: The S and M scratch registers are independent; a write through any target of one mode leaves the other unchanged.
- R12: An access that raises `illegal` asserts neither `rd_we` nor `scr_we` and leaves both scratch registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Access issued this cycle |
| op_tgt | input | 2 | Target: 0 plain, 1 privilege swap, 2 level swap, 3 reserved |
| op_mode | input | 2 | Privilege whose scratch register is addressed |
| op_form | input | 3 | CSR instruction form code |
| rd_idx | input | REG_IDX_W | Destination register index |
| rs1_idx | input | REG_IDX_W | Source register index or immediate |
| src_val | input | XLEN | Source register value |
| cur_priv | input | 2 | Current privilege of the hart |
| prev_priv | input | 2 | Saved previous privilege of the addressed mode |
| prev_lvl | input | LVL_W | Saved previous interrupt level |
| act_lvl | input | LVL_W | Active interrupt level |
| rd_we | output | 1 | Destination register write enable |
| rd_val | output | XLEN | Value for the destination register |
| scr_we | output | 1 | Scratch register written at this result |
| scr_wdata | output | XLEN | Value written into the scratch register |
| illegal | output | 1 | Reserved access, raise illegal instruction |

## Verification
Each access is driven on a falling edge and captured at the next rising edge. All five outputs and the scratch update are therefore due exactly one rising edge later, and the bench compares them on the following falling edge before the next access is driven. Because the scratch update lands at that same edge, the next access in the sweep already sees the new value. The bench's model carries the expected scratch contents from access to access, so a missed or extra write shows up on a later `rd_val`. Idle cycles are checked in the same half-cycle window to confirm that nothing is left asserted.

// File: rtl/cswp_pkg.sv
package cswp_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        TGT_PLAIN = 2'd0,
        TGT_PSWAP = 2'd1,
        TGT_LSWAP = 2'd2,
        TGT_RSV   = 2'd3
    } tgt_e;

    typedef enum logic [2:0] {
        FORM_RSV0 = 3'd0,
        FORM_RW   = 3'd1,
        FORM_RS   = 3'd2,
        FORM_RC   = 3'd3,
        FORM_RSV4 = 3'd4,
        FORM_RWI  = 3'd5,
        FORM_RSI  = 3'd6,
        FORM_RCI  = 3'd7
    } form_e;

    localparam int unsigned NSLOT  = 2;
    localparam int unsigned SLOT_S = 0;
    localparam int unsigned SLOT_M = 1;

endpackage

// File: rtl/cswp_decode.sv
module cswp_decode
    import cswp_pkg::*;
#(
    parameter int unsigned LVL_W     = 8,
    parameter int unsigned REG_IDX_W = 5,
    parameter int unsigned HAS_S     = 1
) (
    input  logic                 valid,
    input  logic [1:0]           tgt,
    input  logic [1:0]           mode,
    input  logic [2:0]           form,
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  logic [REG_IDX_W-1:0] rs1_idx,
    input  logic [1:0]           cur_priv,
    input  logic [1:0]           prev_priv,
    input  logic [LVL_W-1:0]     prev_lvl,
    input  logic [LVL_W-1:0]     act_lvl,
    output logic                 illegal,
    output logic                 is_swap,
    output logic                 swap_go,
    output logic                 plain_wr
);

    logic mode_impl;
    logic form_ok;
    logic swap_form_ok;
    logic priv_ok;
    logic prev_zero;
    logic act_zero;

    always_comb begin
        mode_impl    = (mode == PRIV_M) || ((HAS_S != 0) && (mode == PRIV_S));
        form_ok      = (form != FORM_RSV0) && (form != FORM_RSV4);
        is_swap      = (tgt == TGT_PSWAP) || (tgt == TGT_LSWAP);
        swap_form_ok = (form == FORM_RW) && (rd_idx != '0) && (rs1_idx != '0);
        priv_ok      = (mode <= cur_priv);
        illegal      = valid && (!mode_impl || !priv_ok || (tgt == TGT_RSV) ||
                                 !form_ok || (is_swap && !swap_form_ok));
        prev_zero    = (prev_lvl == '0);
        act_zero     = (act_lvl == '0);
        if (tgt == TGT_PSWAP) begin
            swap_go = (prev_priv != cur_priv);
        end else begin
            swap_go = prev_zero ^ act_zero;
        end
        plain_wr = (form[1:0] == 2'b01) || (rs1_idx != '0);
    end

endmodule

// File: rtl/cswp_plain_alu.sv
module cswp_plain_alu #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned REG_IDX_W = 5
) (
    input  logic [XLEN-1:0]      old_val,
    input  logic [2:0]           form,
    input  logic [XLEN-1:0]      src_val,
    input  logic [REG_IDX_W-1:0] uimm,
    output logic [XLEN-1:0]      new_val
);

    logic [XLEN-1:0] operand;

    always_comb begin
        operand = form[2] ? {{(XLEN-REG_IDX_W){1'b0}}, uimm} : src_val;
        unique case (form[1:0])
            2'b01:   new_val = operand;
            2'b10:   new_val = old_val | operand;
            2'b11:   new_val = old_val & ~operand;
            default: new_val = old_val;
        endcase
    end

endmodule

// File: rtl/cswp_bank.sv
module cswp_bank
    import cswp_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned HAS_S = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic            sel_m,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);

    logic [XLEN-1:0] slot_rd [NSLOT];

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        if ((g == SLOT_S) && (HAS_S == 0)) begin : g_absent
            assign slot_rd[g] = '0;
        end else begin : g_reg
            logic [XLEN-1:0] val_d;
            logic [XLEN-1:0] val_q;

            always_comb begin
                val_d = val_q;
                if (we && (sel_m == (g == SLOT_M))) begin
                    val_d = wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else begin
                    val_q <= val_d;
                end
            end

            assign slot_rd[g] = val_q;
        end
    end

    assign rdata = sel_m ? slot_rd[SLOT_M] : slot_rd[SLOT_S];

endmodule

// File: rtl/cswp_unit.sv
module cswp_unit
    import cswp_pkg::*;
#(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned LVL_W     = 8,
    parameter int unsigned REG_IDX_W = 5,
    parameter int unsigned HAS_S     = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [1:0]           op_tgt,
    input  logic [1:0]           op_mode,
    input  logic [2:0]           op_form,
    input  logic [REG_IDX_W-1:0] rd_idx,
    input  logic [REG_IDX_W-1:0] rs1_idx,
    input  logic [XLEN-1:0]      src_val,
    input  logic [1:0]           cur_priv,
    input  logic [1:0]           prev_priv,
    input  logic [LVL_W-1:0]     prev_lvl,
    input  logic [LVL_W-1:0]     act_lvl,
    output logic                 rd_we,
    output logic [XLEN-1:0]      rd_val,
    output logic                 scr_we,
    output logic [XLEN-1:0]      scr_wdata,
    output logic                 illegal
);

    typedef struct packed {
        logic            rd_we;
        logic [XLEN-1:0] rd_val;
        logic            scr_we;
        logic [XLEN-1:0] scr_wdata;
        logic            illegal;
    } res_t;

    res_t res_d;
    res_t res_q;

    logic            dec_illegal;
    logic            dec_is_swap;
    logic            dec_swap_go;
    logic            dec_plain_wr;
    logic            bank_we;
    logic [XLEN-1:0] bank_wdata;
    logic [XLEN-1:0] bank_rdata;
    logic [XLEN-1:0] alu_new;

    cswp_decode #(
        .LVL_W     (LVL_W),
        .REG_IDX_W (REG_IDX_W),
        .HAS_S     (HAS_S)
    ) u_decode (
        .valid     (op_valid),
        .tgt       (op_tgt),
        .mode      (op_mode),
        .form      (op_form),
        .rd_idx    (rd_idx),
        .rs1_idx   (rs1_idx),
        .cur_priv  (cur_priv),
        .prev_priv (prev_priv),
        .prev_lvl  (prev_lvl),
        .act_lvl   (act_lvl),
        .illegal   (dec_illegal),
        .is_swap   (dec_is_swap),
        .swap_go   (dec_swap_go),
        .plain_wr  (dec_plain_wr)
    );

    cswp_plain_alu #(
        .XLEN      (XLEN),
        .REG_IDX_W (REG_IDX_W)
    ) u_alu (
        .old_val (bank_rdata),
        .form    (op_form),
        .src_val (src_val),
        .uimm    (rs1_idx),
        .new_val (alu_new)
    );

    cswp_bank #(
        .XLEN  (XLEN),
        .HAS_S (HAS_S)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .sel_m (op_mode == PRIV_M),
        .wdata (bank_wdata),
        .rdata (bank_rdata)
    );

    always_comb begin
        res_d      = '0;
        bank_we    = 1'b0;
        bank_wdata = '0;
        if (op_valid) begin
            if (dec_illegal) begin
                res_d.illegal = 1'b1;
            end else if (dec_is_swap) begin
                res_d.rd_we  = 1'b1;
                res_d.rd_val = dec_swap_go ? bank_rdata : src_val;
                if (dec_swap_go) begin
                    bank_we    = 1'b1;
                    bank_wdata = src_val;
                end
            end else begin
                res_d.rd_we  = (rd_idx != '0);
                res_d.rd_val = (rd_idx != '0) ? bank_rdata : '0;
                if (dec_plain_wr) begin
                    bank_we    = 1'b1;
                    bank_wdata = alu_new;
                end
            end
        end
        res_d.scr_we    = bank_we;
        res_d.scr_wdata = bank_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign rd_we     = res_q.rd_we;
    assign rd_val    = res_q.rd_val;
    assign scr_we    = res_q.scr_we;
    assign scr_wdata = res_q.scr_wdata;
    assign illegal   = res_q.illegal;

endmodule

// File: rtl/cswp_unit_chk.sv
module cswp_unit_chk #(
    parameter int unsigned XLEN      = 32,
    parameter int unsigned LVL_W     = 8,
    parameter int unsigned REG_IDX_W = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 op_valid,
    input logic [1:0]           op_tgt,
    input logic [1:0]           op_mode,
    input logic [2:0]           op_form,
    input logic [REG_IDX_W-1:0] rd_idx,
    input logic [REG_IDX_W-1:0] rs1_idx,
    input logic [XLEN-1:0]      src_val,
    input logic [1:0]           cur_priv,
    input logic [1:0]           prev_priv,
    input logic [LVL_W-1:0]     prev_lvl,
    input logic [LVL_W-1:0]     act_lvl,
    input logic                 rd_we,
    input logic [XLEN-1:0]      rd_val,
    input logic                 scr_we,
    input logic [XLEN-1:0]      scr_wdata,
    input logic                 illegal
);

    logic m_swap_ok;
    assign m_swap_ok = op_valid && (op_mode == 2'd3) && (cur_priv == 2'd3) &&
                       (op_form == 3'd1) && (rd_idx != '0) && (rs1_idx != '0);

    p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!rd_we && !scr_we));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!rd_we && !scr_we && !illegal));

    p_swap_rdwe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_swap_ok && ((op_tgt == 2'd1) || (op_tgt == 2'd2))) |=> (rd_we && !illegal));

    p_pswap_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (m_swap_ok && (op_tgt == 2'd1) && (prev_priv != cur_priv))
        |=> (scr_we && (scr_wdata == $past(src_val))));

    p_pswap_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (m_swap_ok && (op_tgt == 2'd1) && (prev_priv == cur_priv))
        |=> (!scr_we && (rd_val == $past(src_val))));

    p_lswap_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m_swap_ok && (op_tgt == 2'd2))
        |=> (scr_we == ($past(prev_lvl == '0) != $past(act_lvl == '0))));

    p_higher_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_mode > cur_priv)) |=> illegal);

    p_lowest_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_mode == 2'd0)) |=> illegal);

    p_swap_x0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_tgt != 2'd0) && ((rd_idx == '0) || (rs1_idx == '0))) |=> illegal);

endmodule

bind cswp_unit cswp_unit_chk #(
    .XLEN      (XLEN),
    .LVL_W     (LVL_W),
    .REG_IDX_W (REG_IDX_W)
) u_chk (.*);

// File: tb/cswp_unit_tb.sv
module cswp_unit_tb;

    localparam int XLEN = 32;
    localparam int LVW  = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            op_valid = 1'b0;
    logic [1:0]      op_tgt = '0;
    logic [1:0]      op_mode = '0;
    logic [2:0]      op_form = '0;
    logic [4:0]      rd_idx = '0;
    logic [4:0]      rs1_idx = '0;
    logic [XLEN-1:0] src_val = '0;
    logic [1:0]      cur_priv = '0;
    logic [1:0]      prev_priv = '0;
    logic [LVW-1:0]  prev_lvl = '0;
    logic [LVW-1:0]  act_lvl = '0;
    logic            rd_we;
    logic [XLEN-1:0] rd_val;
    logic            scr_we;
    logic [XLEN-1:0] scr_wdata;
    logic            illegal;

    int checks = 0;
    int fails  = 0;

    logic [XLEN-1:0] m_scr [2];
    logic            e_ill, e_rdwe, e_scrwe;
    logic [XLEN-1:0] e_rdval, e_wdata;
    string           e_tag;

    cswp_unit u_dut (.*);

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model();
        bit impl, bad, swap, go, wr;
        int slot;
        logic [XLEN-1:0] opnd, old, nv;
        impl  = (op_mode == 2'd3) || (op_mode == 2'd1);
        swap  = (op_tgt == 2'd1) || (op_tgt == 2'd2);
        slot  = (op_mode == 2'd3) ? 1 : 0;
        old   = m_scr[slot];
        e_ill = 0; e_rdwe = 0; e_scrwe = 0; e_rdval = '0; e_wdata = '0;
        if (!impl) e_tag = "R7";
        else if (op_mode > cur_priv) e_tag = "R6";
        else if (op_tgt == 2'd0) e_tag = "R8";
        else if (op_tgt == 2'd1) e_tag = (prev_priv != cur_priv) ? "R2" : "R3";
        else e_tag = "R4";
        bad = !impl || (op_mode > cur_priv) || (op_tgt == 2'd3) ||
              (op_form == 3'd0) || (op_form == 3'd4) ||
              (swap && ((op_form != 3'd1) || (rd_idx == 0) || (rs1_idx == 0)));
        if (bad) begin
            if (impl && (op_mode <= cur_priv)) e_tag = "R5";
            e_ill = 1;
            return;
        end
        if (swap) begin
            go = (op_tgt == 2'd1) ? (prev_priv != cur_priv)
                                  : ((prev_lvl == 0) != (act_lvl == 0));
            e_rdwe  = 1;
            e_rdval = go ? old : src_val;
            if (go) begin
                e_scrwe = 1; e_wdata = src_val; m_scr[slot] = src_val;
            end
        end else begin
            opnd = op_form[2] ? {27'd0, rs1_idx} : src_val;
            case (op_form[1:0])
                2'b01:   nv = opnd;
                2'b10:   nv = old | opnd;
                default: nv = old & ~opnd;
            endcase
            wr = (op_form[1:0] == 2'b01) || (rs1_idx != 0);
            e_rdwe  = (rd_idx != 0);
            e_rdval = (rd_idx != 0) ? old : '0;
            if (wr) begin
                e_scrwe = 1; e_wdata = nv; m_scr[slot] = nv;
            end
        end
    endfunction

    task automatic run_op(input logic [1:0] t, input logic [1:0] m, input logic [2:0] f,
                          input logic [4:0] rd, input logic [4:0] rs,
                          input logic [XLEN-1:0] s, input logic [1:0] cp,
                          input logic [1:0] pp, input logic [LVW-1:0] pl,
                          input logic [LVW-1:0] al);
        op_valid = 1; op_tgt = t; op_mode = m; op_form = f; rd_idx = rd; rs1_idx = rs;
        src_val = s; cur_priv = cp; prev_priv = pp; prev_lvl = pl; act_lvl = al;
        model();
        @(negedge clk);
        check(illegal == e_ill, {e_tag, " illegal"}, {31'd0, illegal}, {31'd0, e_ill});
        check(rd_we == e_rdwe, {e_tag, " rd_we"}, {31'd0, rd_we}, {31'd0, e_rdwe});
        check(rd_val == e_rdval, {e_tag, " rd_val"}, rd_val, e_rdval);
        check(scr_we == e_scrwe, {e_tag, " scr_we"}, {31'd0, scr_we}, {31'd0, e_scrwe});
        check(scr_wdata == e_wdata, {e_tag, " scr_wdata"}, scr_wdata, e_wdata);
        if (e_ill) check(!rd_we && !scr_we, "R12 quiet", {31'd0, scr_we}, '0);
        if (!e_ill && (t != 2'd0)) check(rd_we, "R10 rd_we", {31'd0, rd_we}, 32'd1);
    endtask

    task automatic idle_check();
        op_valid = 0; op_tgt = 2'd1; op_form = 3'd1; rd_idx = 5; rs1_idx = 7;
        op_mode = 2'd3; cur_priv = 2'd3; prev_priv = 2'd0; src_val = 32'hDEAD_BEEF;
        @(negedge clk);
        check(!rd_we && !scr_we && !illegal && rd_val == 0 && scr_wdata == 0,
              "R9 idle", rd_val | scr_wdata, '0);
    endtask

    initial begin
        int n;
        m_scr[0] = '0; m_scr[1] = '0;
        repeat (3) @(negedge clk);
        check(!rd_we && !scr_we && !illegal && rd_val == 0 && scr_wdata == 0,
              "R1 reset outputs", rd_val, '0);
        rst_n = 1;
        @(negedge clk);
        run_op(2'd0, 2'd3, 3'd2, 5'd3, 5'd0, 32'hFFFF_FFFF, 2'd3, 2'd0, 0, 0);
        check(rd_val == 0, "R1 M scratch zero", rd_val, '0);
        run_op(2'd0, 2'd1, 3'd2, 5'd3, 5'd0, 32'hFFFF_FFFF, 2'd3, 2'd0, 0, 0);
        check(rd_val == 0, "R1 S scratch zero", rd_val, '0);
        // R11: independent slots
        run_op(2'd0, 2'd3, 3'd1, 5'd0, 5'd4, 32'h1111_2222, 2'd3, 2'd0, 0, 0);
        run_op(2'd1, 2'd1, 3'd1, 5'd2, 5'd4, 32'h3333_4444, 2'd3, 2'd1, 0, 0);
        run_op(2'd0, 2'd3, 3'd2, 5'd3, 5'd0, 32'h0, 2'd3, 2'd0, 0, 0);
        check(rd_val == 32'h1111_2222, "R11 M kept", rd_val, 32'h1111_2222);
        run_op(2'd0, 2'd1, 3'd2, 5'd3, 5'd0, 32'h0, 2'd3, 2'd0, 0, 0);
        check(rd_val == 32'h3333_4444, "R11 S written", rd_val, 32'h3333_4444);
        idle_check();
        n = 0;
        for (int f = 0; f < 8; f++)
            for (int t = 0; t < 4; t++)
                for (int m = 0; m < 4; m++)
                    for (int cp = 0; cp < 4; cp++)
                        for (int pp = 0; pp < 4; pp++)
                            for (int x = 0; x < 16; x++) begin
                                n++;
                                run_op(2'(t), 2'(m), 3'(f), x[0] ? 5'd9 : 5'd0,
                                       x[1] ? 5'd6 : 5'd0,
                                       (32'(n) * 32'h9E37_79B9) ^ (32'(n) << 7),
                                       2'(cp), 2'(pp), x[2] ? 8'd3 : 8'd0,
                                       x[3] ? 8'd9 : 8'd0);
                                if ((n % 1024) == 0) idle_check();
                            end
        idle_check();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule